// File: doc/BRIEF.md
# Job-Sequence Mutate-and-Merge Unit

This block takes one candidate schedule and pulls it part of the way towards the best schedule found so far. A schedule is a vector of job identifiers. The k-th time a job identifier appears in the vector stands for that job's k-th operation. The unit works in two steps. First it swaps the elements at two pseudo-random positions. Then it copies the best vector's elements into a pseudo-random subset of positions, and rebuilds the other positions from what is left. After the rebuild, every job still appears exactly as many times as it did before.

A population of N candidates uses N copies of this unit side by side. Each copy gets its own seed. A caller pulses start with the current vector, the best vector and a 16-bit seed. The result appears a fixed number of cycles later, marked by a one-cycle done pulse. The unit does not evaluate fitness.

Top module: `perm_merge_unit`

## Requirements
- R1: While reset is asserted and after it is released, done_o is 0 and vec_o is all zeros until the first result.
- R2: Element i of any vector sits at bits [i*IDW +: IDW], with position 0 in the least significant bits. The current and best vectors hold the same multiset of job IDs, and the output holds that same multiset.
- R3: On an accepted start, a 16-bit generator is loaded with seed_i. A zero seed is replaced by 16'hACE1. Each step maps state s to (s >> 1), XORed with 16'hB400 when s[0] is 1.
- R4: The first swap position is (r * LEN) >> 8, where r is the low byte of the loaded generator state. The second swap position uses the same formula on the low byte after one step. The elements at these two positions are exchanged. When both positions are equal, the vector is unchanged.
- R5: The merge mask is the low LEN bits of the generator state after two steps, where bit i selects position i. Every selected position of vec_o equals the best vector's element at that position.
- R6: To build the leftover list, scan the mutated vector from position 0 upward. An element whose job still has a pending count is dropped, and that count goes down by one. The pending counts start as the number of selected positions that carry each job. The elements kept by the scan fill the unselected positions in ascending order.
- R7: An all-zero mask returns the mutated vector unchanged. An all-ones mask returns the best vector.
- R8: done_o is high for exactly one cycle: the cycle after the fourth rising edge that follows the edge that sampled start_i. vec_o is valid in that cycle.
- R9: A start pulse that arrives while a step is in progress is ignored. It does not change the result or the timing of the step in progress.
- R10: vec_o holds its value between results and changes only in the cycle in which done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start pulse, accepted only when the unit is idle |
| cur_i | input | LEN*IDW | Current candidate vector |
| best_i | input | LEN*IDW | Best-known vector |
| seed_i | input | 16 | Generator seed |
| vec_o | output | LEN*IDW | Resulting vector |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
Every result is due at the same point: four rising edges after the edge that sampled start, with no dependence on the data or on whether the swap is a no-op. The bench drives inputs on falling edges and counts falling edges from the start pulse. It confirms that done_o is still low one cycle before the result and samples vec_o on the fifth falling edge. It looks again one cycle later to confirm that done_o has dropped and vec_o has held. A start pulse injected in the busy window lands exactly one edge into the step, which is where an ignored start would most easily cause damage.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam logic [15:0] GEN_TAPS     = 16'hB400;
  localparam logic [15:0] GEN_FALLBACK = 16'hACE1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK_A,
    ST_PICK_B,
    ST_SWAP,
    ST_MERGE
  } step_e;

  // Maps a random byte onto 0..n-1 by multiply and shift (no divider).
  function automatic logic [7:0] scale_pick(input logic [7:0] r, input logic [7:0] n);
    logic [15:0] prod;
    prod = {8'd0, r} * {8'd0, n};
    return prod[15:8];
  endfunction

endpackage

// File: rtl/pmu_rng.sv
module pmu_rng
  import pmu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_en,
  input  logic        step_en,
  input  logic [15:0] seed,
  output logic [15:0] state
);

  logic [15:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (load_en) begin
      state_d = (seed == 16'd0) ? GEN_FALLBACK : seed;
    end else if (step_en) begin
      state_d = state_q[0] ? ((state_q >> 1) ^ GEN_TAPS) : (state_q >> 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GEN_FALLBACK;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R3: the generator never reaches the all-zero lock-up state
  a_r3_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 16'd0);

endmodule

// File: rtl/pmu_swap.sv
module pmu_swap #(
  parameter int LEN = 12,
  parameter int IDW = 4,
  localparam int PW = $clog2(LEN),
  localparam int VW = LEN * IDW
) (
  input  logic [VW-1:0] vec,
  input  logic [PW-1:0] pos_a,
  input  logic [PW-1:0] pos_b,
  output logic [VW-1:0] swapped
);

  always_comb begin
    swapped = vec;
    swapped[pos_a*IDW +: IDW] = vec[pos_b*IDW +: IDW];
    swapped[pos_b*IDW +: IDW] = vec[pos_a*IDW +: IDW];
  end

endmodule

// File: rtl/pmu_repair.sv
module pmu_repair #(
  parameter int LEN = 12,
  parameter int IDW = 4,
  localparam int VW = LEN * IDW,
  localparam int NJ = 1 << IDW,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic [VW-1:0]  mutated,
  input  logic [VW-1:0]  best,
  input  logic [LEN-1:0] mask,
  output logic [VW-1:0]  merged
);

  logic [CW-1:0]  pend [NJ];
  logic [IDW-1:0] left [LEN];
  logic [IDW-1:0] elem;
  int             wr;
  int             rd;

  always_comb begin
    for (int j = 0; j < NJ; j++) pend[j] = '0;
    for (int i = 0; i < LEN; i++) left[i] = '0;
    elem   = '0;
    wr     = 0;
    rd     = 0;
    merged = '0;

    // pending removals: imported copies of each job
    for (int i = 0; i < LEN; i++) begin
      if (mask[i]) pend[best[i*IDW +: IDW]] = pend[best[i*IDW +: IDW]] + CW'(1);
    end

    // compact the mutated vector, skipping one copy per pending removal
    for (int i = 0; i < LEN; i++) begin
      elem = mutated[i*IDW +: IDW];
      if (pend[elem] != '0) begin
        pend[elem] = pend[elem] - CW'(1);
      end else if (wr < LEN) begin
        left[wr] = elem;
        wr = wr + 1;
      end
    end

    // fill: imported at masked positions, leftovers in order elsewhere
    for (int i = 0; i < LEN; i++) begin
      if (mask[i]) begin
        merged[i*IDW +: IDW] = best[i*IDW +: IDW];
      end else begin
        merged[i*IDW +: IDW] = (rd < LEN) ? left[rd] : '0;
        rd = rd + 1;
      end
    end
  end

endmodule

// File: rtl/perm_merge_unit.sv
module perm_merge_unit
  import pmu_pkg::*;
#(
  parameter int LEN = 12,
  parameter int IDW = 4,
  localparam int PW = $clog2(LEN),
  localparam int VW = LEN * IDW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [VW-1:0] cur_i,
  input  logic [VW-1:0] best_i,
  input  logic [15:0]   seed_i,
  output logic [VW-1:0] vec_o,
  output logic          done_o
);

  step_e          state_q, state_d;
  logic [VW-1:0]  cur_q, best_q, out_q;
  logic [PW-1:0]  pos_a_q, pos_b_q;
  logic [LEN-1:0] mask_q;
  logic           done_q;
  logic [15:0]    rnd;
  logic [VW-1:0]  swapped, merged;

  logic load_en, step_en, cap_a, cap_b, do_swap, do_out;

  pmu_rng u_rng (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .step_en (step_en),
    .seed    (seed_i),
    .state   (rnd)
  );

  pmu_swap #(.LEN(LEN), .IDW(IDW)) u_swap (
    .vec     (cur_q),
    .pos_a   (pos_a_q),
    .pos_b   (pos_b_q),
    .swapped (swapped)
  );

  pmu_repair #(.LEN(LEN), .IDW(IDW)) u_repair (
    .mutated (cur_q),
    .best    (best_q),
    .mask    (mask_q),
    .merged  (merged)
  );

  // next-state and control
  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    step_en = 1'b0;
    cap_a   = 1'b0;
    cap_b   = 1'b0;
    do_swap = 1'b0;
    do_out  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_en = 1'b1;
          state_d = ST_PICK_A;
        end
      end
      ST_PICK_A: begin
        cap_a   = 1'b1;
        step_en = 1'b1;
        state_d = ST_PICK_B;
      end
      ST_PICK_B: begin
        cap_b   = 1'b1;
        step_en = 1'b1;
        state_d = ST_SWAP;
      end
      ST_SWAP: begin
        do_swap = 1'b1;
        state_d = ST_MERGE;
      end
      ST_MERGE: begin
        do_out  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      best_q  <= '0;
      pos_a_q <= '0;
      pos_b_q <= '0;
      mask_q  <= '0;
      out_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= do_out;
      if (load_en) begin
        cur_q  <= cur_i;
        best_q <= best_i;
      end else if (do_swap) begin
        cur_q  <= swapped;
      end
      if (cap_a)   pos_a_q <= PW'(scale_pick(rnd[7:0], 8'(LEN)));
      if (cap_b)   pos_b_q <= PW'(scale_pick(rnd[7:0], 8'(LEN)));
      if (do_swap) mask_q  <= rnd[LEN-1:0];
      if (do_out)  out_q   <= merged;
    end
  end

  assign vec_o  = out_q;
  assign done_o = done_q;

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10: the output only moves in the done cycle
  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> done_q);

  // R9: a step in progress proceeds whatever start does
  a_r9_busy_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PICK_A) |=> (state_q == ST_PICK_B));

  // R4: both swap positions are inside the vector
  a_r4_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SWAP) |-> ((32'(pos_a_q) < LEN) && (32'(pos_b_q) < LEN)));

  // R5: selected positions of a fresh result carry the best vector's element
  for (genvar g = 0; g < LEN; g++) begin : g_mask_chk
    a_r5_import: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && mask_q[g]) |-> (out_q[g*IDW +: IDW] == best_q[g*IDW +: IDW]));
  end

endmodule

// File: tb/perm_merge_unit_tb.sv
module perm_merge_unit_tb;

  localparam int  LEN = 12;
  localparam int  IDW = 4;
  localparam int  VW  = LEN * IDW;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NROW = 6;

  localparam logic [VW-1:0] T_CUR [NROW] = '{
    48'h333222111000, 48'h554433221100, 48'h222211110000,
    48'h012301230123, 48'h000000000000, 48'hBA9876543210 };
  localparam logic [VW-1:0] T_BEST [NROW] = '{
    48'h012301230123, 48'h012345012345, 48'h210210210210,
    48'h333222111000, 48'h000000000000, 48'h0123456789AB };
  localparam logic [15:0] T_SEED [NROW] = '{
    16'h1D2F, 16'h8001, 16'h5A5A, 16'hF00D, 16'h3C3C, 16'h7E11 };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [VW-1:0] cur_i = '0;
  logic [VW-1:0] best_i = '0;
  logic [15:0]   seed_i = '0;
  logic [VW-1:0] vec_o;
  logic          done_o;

  int checks = 0;
  int failures = 0;

  perm_merge_unit #(.LEN(LEN), .IDW(IDW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cur_i(cur_i),
    .best_i(best_i), .seed_i(seed_i), .vec_o(vec_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model built from the requirements
  function automatic logic [15:0] gen_step(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

  function automatic int pick(input logic [7:0] r);
    return (int'(r) * LEN) / 256;
  endfunction

  function automatic logic [15:0] mask_of(input logic [15:0] seed);
    logic [15:0] s;
    s = (seed == 16'd0) ? 16'hACE1 : seed;
    return gen_step(gen_step(s));
  endfunction

  function automatic logic [VW-1:0] model(input logic [VW-1:0] cur, input logic [VW-1:0] best,
                                          input logic [15:0] seed);
    logic [15:0]    s;
    int             a, b, nleft, k;
    logic [IDW-1:0] t;
    logic [VW-1:0]  m, res;
    int             need [16];
    logic [IDW-1:0] lst [LEN];
    logic [LEN-1:0] msk;
    s = (seed == 16'd0) ? 16'hACE1 : seed;
    a = pick(s[7:0]);
    s = gen_step(s);
    b = pick(s[7:0]);
    s = gen_step(s);
    msk = s[LEN-1:0];
    m = cur;
    t = m[a*IDW +: IDW];
    m[a*IDW +: IDW] = m[b*IDW +: IDW];
    m[b*IDW +: IDW] = t;
    for (int j = 0; j < 16; j++) need[j] = 0;
    for (int i = 0; i < LEN; i++) if (msk[i]) need[best[i*IDW +: IDW]]++;
    nleft = 0;
    for (int i = 0; i < LEN; i++) lst[i] = '0;
    for (int i = 0; i < LEN; i++) begin
      t = m[i*IDW +: IDW];
      if (need[t] > 0) need[t]--;
      else begin lst[nleft] = t; nleft++; end
    end
    k = 0;
    res = '0;
    for (int i = 0; i < LEN; i++) begin
      if (msk[i]) res[i*IDW +: IDW] = best[i*IDW +: IDW];
      else begin res[i*IDW +: IDW] = lst[k]; k++; end
    end
    return res;
  endfunction

  function automatic bit same_multiset(input logic [VW-1:0] x, input logic [VW-1:0] y);
    int cnt [16];
    for (int j = 0; j < 16; j++) cnt[j] = 0;
    for (int i = 0; i < LEN; i++) begin
      cnt[x[i*IDW +: IDW]]++;
      cnt[y[i*IDW +: IDW]]--;
    end
    for (int j = 0; j < 16; j++) if (cnt[j] != 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit masked_ok(input logic [VW-1:0] r, input logic [VW-1:0] best,
                                   input logic [15:0] seed);
    logic [15:0] mk;
    mk = mask_of(seed);
    for (int i = 0; i < LEN; i++)
      if (mk[i] && r[i*IDW +: IDW] != best[i*IDW +: IDW]) return 1'b0;
    return 1'b1;
  endfunction

  // one full step; optionally injects a start while busy
  task automatic run(input logic [VW-1:0] cur, input logic [VW-1:0] best,
                     input logic [15:0] seed, input bit inject, output logic [VW-1:0] got);
    logic [VW-1:0] held;
    @(negedge clk);
    cur_i = cur; best_i = best; seed_i = seed; start_i = 1'b1;
    @(negedge clk);                    // after the edge that sampled start
    start_i = inject;
    if (inject) begin
      cur_i = best; best_i = cur; seed_i = ~seed;
    end
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(done_o == 1'b0, "R8 done early", {47'd0, done_o}, '0);
    @(negedge clk);
    check(done_o == 1'b1, "R8 done missing", {47'd0, done_o}, {47'd0, 1'b1});
    got  = vec_o;
    held = vec_o;
    @(negedge clk);
    check(done_o == 1'b0, "R8 done width", {47'd0, done_o}, '0);
    check(vec_o == held, "R10 output hold", vec_o, held);
  endtask

  logic [VW-1:0] got, exp, swp;
  logic [15:0]   s_zero, s_ones, s_same, s2;
  int            pa;

  initial begin
    // R1: reset state
    #(CLK_PERIOD*2);
    check(done_o == 1'b0, "R1 done in reset", {47'd0, done_o}, '0);
    check(vec_o == '0, "R1 vec in reset", vec_o, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0 && vec_o == '0, "R1 after release", vec_o, '0);

    // table walk: R2 R4 R5 R6
    for (int r = 0; r < NROW; r++) begin
      run(T_CUR[r], T_BEST[r], T_SEED[r], 1'b0, got);
      exp = model(T_CUR[r], T_BEST[r], T_SEED[r]);
      check(got == exp, "R6 merge result", got, exp);
      check(same_multiset(got, T_CUR[r]), "R2 multiset kept", got, T_CUR[r]);
      check(masked_ok(got, T_BEST[r], T_SEED[r]), "R5 imported positions", got, T_BEST[r]);
    end

    // R3: zero seed behaves as the fallback seed
    run(T_CUR[0], T_BEST[0], 16'h0000, 1'b0, got);
    exp = model(T_CUR[0], T_BEST[0], 16'hACE1);
    check(got == exp, "R3 zero seed", got, exp);

    // search seeds for corner masks and coincident swap positions
    s_zero = 16'd0; s_ones = 16'd0; s_same = 16'd0;
    for (int v = 1; v < 65536; v++) begin
      s2 = mask_of(16'(v));
      if (s_zero == 16'd0 && s2[LEN-1:0] == '0) s_zero = 16'(v);
      if (s_ones == 16'd0 && s2[LEN-1:0] == '1) s_ones = 16'(v);
      if (s_same == 16'd0 && pick(8'(v)) == pick(gen_step(16'(v)) >> 0 & 16'h00FF ? 8'(gen_step(16'(v))) : 8'(gen_step(16'(v)))))
        s_same = 16'(v);
    end

    // R7: all-zero mask returns the mutated vector
    run(T_CUR[5], T_BEST[5], s_zero, 1'b0, got);
    pa  = pick(s_zero[7:0]);
    swp = T_CUR[5];
    swp[pa*IDW +: IDW] = T_CUR[5][pick(8'(gen_step(s_zero)))*IDW +: IDW];
    swp[pick(8'(gen_step(s_zero)))*IDW +: IDW] = T_CUR[5][pa*IDW +: IDW];
    check(got == swp, "R7 zero mask passthrough", got, swp);

    // R7: all-ones mask returns the best vector
    run(T_CUR[1], T_BEST[1], s_ones, 1'b0, got);
    check(got == T_BEST[1], "R7 full mask", got, T_BEST[1]);

    // R4: equal swap positions leave the vector alone before merging
    run(T_CUR[5], T_BEST[5], s_same, 1'b0, got);
    exp = model(T_CUR[5], T_BEST[5], s_same);
    check(got == exp, "R4 same position", got, exp);

    // R9: start while busy is ignored
    run(T_CUR[2], T_BEST[2], T_SEED[2], 1'b1, got);
    exp = model(T_CUR[2], T_BEST[2], T_SEED[2]);
    check(got == exp, "R9 busy start ignored", got, exp);
    repeat (6) @(negedge clk);
    check(done_o == 1'b0 && vec_o == got, "R9 no extra result", vec_o, got);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule